// File: doc/BRIEF.md
# Packed Byte Buffer with Endian Swap

This block is a four-byte shift buffer that sits between a 16-bit host data register and a byte-serial line engine. In the transmit direction the host loads the buffer one word at a time, or one byte for a final odd byte, and the engine removes bytes one by one. In the receive direction the engine deposits bytes one by one and the host drains them a word at a time. One buffer is shared by both directions. Each direction has its own pending-byte counter.

A byte-order input selects how the two bytes of a host word map onto the buffer. With the input low, the low byte of a written word is sent first. With it high, the word is stored as written. Reads apply the matching inverse mapping.

The block reports underflow, overrun and single-byte-read conditions to a neighbouring status unit. It also sends that unit one-cycle requests to drop its transmit-ready and receive-ready indications. A start command clears the buffer, both counters and all flags. Only one operation acts in each cycle, chosen by a fixed priority.

Top module: `pbb_byte_buffer`

## Requirements
- R1: After reset or a start command, both counters are 0, every flag and pulse output is 0, and the host read word is 0x0000.
- R2: An accepted 16-bit host write shifts the buffer left by 16 bits, places the word in bits 15:0 and adds 2 to the transmit count. With `straight_i` low, host bits 7:0 go to buffer bits 15:8 and host bits 15:8 go to buffer bits 7:0. With `straight_i` high, the word is stored unchanged.
- R3: An accepted 8-bit host write shifts the buffer left by 8 bits, places `host_wdata_i[7:0]` in bits 7:0 and adds 1 to the transmit count.
- R4: A host write of either width made while the transmit count is above 2 has no effect on the buffer, the counters, the flags or the pulses.
- R5: An accepted host write clears `underflow_o`. If it leaves more than 2 transmit bytes pending, `tx_ready_clr_o` pulses high for one cycle in the cycle after the write.
- R6: `eng_tx_byte_o` shows buffer byte (transmit count − 1), where byte k is bits 8k+7:8k. A pop decrements the count. With the count at 0, the byte shown is 0x00, a pop leaves the count at 0 and `underflow_o` is set.
- R7: An engine push with receive count n < 4 writes the byte to buffer byte n and increments the count. With n = 4, the byte is dropped, nothing changes and `overrun_o` is set.
- R8: `host_rdata_o` is `{byte1, byte0}` of the buffer when `straight_i` is low and `{byte0, byte1}` when it is high.
- R9: A host read sets the receive count as follows. From 1 it goes to 0 and `single_byte_o` is set. From 2 it goes to 0. From 3 or 4 the buffer shifts right by 16 bits and the count drops by 2. From 0 nothing changes.
- R10: Every host read clears `overrun_o`. A read that leaves the receive count at 0 pulses `rx_ready_clr_o` for one cycle in the cycle after the read.
- R11: When several operations are requested in one cycle, only the highest-priority one acts. The order from highest to lowest is start, 16-bit write, 8-bit write, read, pop, push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command: clears buffer, counters and flags |
| straight_i | input | 1 | Byte order: 0 swaps host word bytes, 1 stores as written |
| host_wr16_i | input | 1 | 16-bit host write strobe |
| host_wr8_i | input | 1 | 8-bit host write strobe (final odd byte) |
| host_wdata_i | input | 16 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 16 | Host read word, valid in the cycle of the read |
| eng_pop_i | input | 1 | Engine takes one transmit byte |
| eng_tx_byte_o | output | 8 | Transmit byte offered to the engine |
| eng_push_i | input | 1 | Engine delivers one received byte |
| eng_rx_byte_i | input | 8 | Received byte |
| tx_count_o | output | 3 | Pending transmit bytes |
| rx_count_o | output | 3 | Pending receive bytes |
| underflow_o | output | 1 | Pop made with no transmit byte pending |
| overrun_o | output | 1 | Push made with the buffer full |
| single_byte_o | output | 1 | A read returned only one valid byte |
| tx_ready_clr_o | output | 1 | One-cycle request to drop transmit-ready |
| rx_ready_clr_o | output | 1 | One-cycle request to drop receive-ready |

## Verification
The buffer, the counters and the three flags change at the clock edge that carries the operation. `host_rdata_o` and `eng_tx_byte_o` are combinational views of that state, so they are due in the same cycle. The two ready-clear pulses are registered and appear in the single cycle after the operating edge, then drop again. The bench drives each operation at a falling edge and steps its own model once per edge. At the next falling edge it compares every output against the model, which places each pulse check exactly one cycle after its cause.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

  localparam int BYTE_W = 8;
  localparam int HOST_W = 16;

  // Operation chosen for one cycle; the numeric order matches priority
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_START = 3'd1,
    OP_WR16  = 3'd2,
    OP_WR8   = 3'd3,
    OP_RD    = 3'd4,
    OP_POP   = 3'd5,
    OP_PUSH  = 3'd6
  } pbb_op_e;

  function automatic logic [HOST_W-1:0] swap_halves(input logic [HOST_W-1:0] w);
    return {w[BYTE_W-1:0], w[HOST_W-1:BYTE_W]};
  endfunction

  // Host word to the two low buffer bytes
  function automatic logic [HOST_W-1:0] host_to_pair(input logic [HOST_W-1:0] w,
                                                     input logic straight);
    return straight ? w : swap_halves(w);
  endfunction

  // Two low buffer bytes to host word (inverse sense of the write path)
  function automatic logic [HOST_W-1:0] pair_to_host(input logic [HOST_W-1:0] p,
                                                     input logic straight);
    return straight ? swap_halves(p) : p;
  endfunction

endpackage

// File: rtl/pbb_op_select.sv
module pbb_op_select
  import pbb_pkg::*;
#(
  parameter int NREQ = 6
) (
  input  logic [NREQ-1:0] req_i,   // bit 0 highest priority
  output pbb_op_e         op_o
);

  always_comb begin
    op_o = OP_IDLE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) op_o = pbb_op_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/pbb_store.sv
module pbb_store
  import pbb_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int BUF_W = DEPTH * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pbb_op_e           op_i,
  input  logic [HOST_W-1:0] wpair_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [BUF_W-1:0]  buf_o,
  output logic [CW-1:0]     tx_o,
  output logic [CW-1:0]     rx_o,
  output logic              ev_wr_acc_o,
  output logic              ev_wr16_acc_o,
  output logic              ev_wr_ign_o,
  output logic              ev_tx_deep_o,
  output logic              ev_pop_empty_o,
  output logic              ev_push_full_o,
  output logic              ev_rd_o,
  output logic              ev_rd_single_o,
  output logic              ev_rd_zero_o
);

  localparam int          HOST_B   = HOST_W / BYTE_W;
  localparam logic [CW-1:0] TX_LIMIT = CW'(DEPTH - HOST_B);
  localparam logic [CW-1:0] HB       = CW'(HOST_B);
  localparam logic [CW-1:0] FULL     = CW'(DEPTH);

  logic [BUF_W-1:0] buf_q;
  logic [CW-1:0]    tx_q, rx_q;

  function automatic logic [CW-1:0] tx_after_write(input logic [CW-1:0] t, input logic wide);
    return t + (wide ? HB : CW'(1));
  endfunction

  function automatic logic [CW-1:0] rx_after_read(input logic [CW-1:0] r);
    return (r > HB) ? r - HB : '0;
  endfunction

  logic is_wr, room;
  assign is_wr = (op_i == OP_WR16) || (op_i == OP_WR8);
  assign room  = (tx_q <= TX_LIMIT);

  assign ev_wr_acc_o    = is_wr && room;
  assign ev_wr16_acc_o  = (op_i == OP_WR16) && room;
  assign ev_wr_ign_o    = is_wr && !room;
  assign ev_tx_deep_o   = ev_wr_acc_o && (tx_after_write(tx_q, op_i == OP_WR16) > HB);
  assign ev_pop_empty_o = (op_i == OP_POP) && (tx_q == '0);
  assign ev_push_full_o = (op_i == OP_PUSH) && (rx_q == FULL);
  assign ev_rd_o        = (op_i == OP_RD);
  assign ev_rd_single_o = ev_rd_o && (rx_q == CW'(1));
  assign ev_rd_zero_o   = ev_rd_o && (rx_after_read(rx_q) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      unique case (op_i)
        OP_START: begin
          buf_q <= '0;
          tx_q  <= '0;
          rx_q  <= '0;
        end
        OP_WR16: if (room) begin
          buf_q <= (buf_q << HOST_W) | BUF_W'(wpair_i);
          tx_q  <= tx_after_write(tx_q, 1'b1);
        end
        OP_WR8: if (room) begin
          buf_q <= (buf_q << BYTE_W) | BUF_W'(wbyte_i);
          tx_q  <= tx_after_write(tx_q, 1'b0);
        end
        OP_RD: begin
          if (rx_q > HB) buf_q <= buf_q >> HOST_W;
          rx_q <= rx_after_read(rx_q);
        end
        OP_POP: if (tx_q != '0) tx_q <= tx_q - CW'(1);
        OP_PUSH: if (rx_q < FULL) begin
          buf_q[rx_q * BYTE_W +: BYTE_W] <= rx_byte_i;
          rx_q <= rx_q + CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign buf_o = buf_q;
  assign tx_o  = tx_q;
  assign rx_o  = rx_q;

endmodule

// File: rtl/pbb_flags.sv
module pbb_flags
  import pbb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pbb_op_e op_i,
  input  logic    ev_wr_acc_i,
  input  logic    ev_tx_deep_i,
  input  logic    ev_pop_empty_i,
  input  logic    ev_push_full_i,
  input  logic    ev_rd_i,
  input  logic    ev_rd_single_i,
  input  logic    ev_rd_zero_i,
  output logic    underflow_o,
  output logic    overrun_o,
  output logic    single_o,
  output logic    tx_clr_o,
  output logic    rx_clr_o
);

  logic start;
  assign start = (op_i == OP_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underflow_o <= 1'b0;
      overrun_o   <= 1'b0;
      single_o    <= 1'b0;
      tx_clr_o    <= 1'b0;
      rx_clr_o    <= 1'b0;
    end else begin
      tx_clr_o <= ev_tx_deep_i;
      rx_clr_o <= ev_rd_zero_i;
      if (start) begin
        underflow_o <= 1'b0;
        overrun_o   <= 1'b0;
        single_o    <= 1'b0;
      end else begin
        if (ev_pop_empty_i)   underflow_o <= 1'b1;
        else if (ev_wr_acc_i) underflow_o <= 1'b0;
        if (ev_push_full_i)   overrun_o <= 1'b1;
        else if (ev_rd_i)     overrun_o <= 1'b0;
        if (ev_rd_single_i)   single_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbb_byte_buffer.sv
module pbb_byte_buffer
  import pbb_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              straight_i,
  input  logic              host_wr16_i,
  input  logic              host_wr8_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [HOST_W-1:0] host_rdata_o,
  input  logic              eng_pop_i,
  output logic [BYTE_W-1:0] eng_tx_byte_o,
  input  logic              eng_push_i,
  input  logic [BYTE_W-1:0] eng_rx_byte_i,
  output logic [CW-1:0]     tx_count_o,
  output logic [CW-1:0]     rx_count_o,
  output logic              underflow_o,
  output logic              overrun_o,
  output logic              single_byte_o,
  output logic              tx_ready_clr_o,
  output logic              rx_ready_clr_o
);

  localparam int BUF_W = DEPTH * BYTE_W;

  pbb_op_e          op;
  logic [BUF_W-1:0] buf_q;
  logic             ev_wr_acc, ev_wr16_acc, ev_wr_ign, ev_tx_deep;
  logic             ev_pop_empty, ev_push_full, ev_rd, ev_rd_single, ev_rd_zero;

  pbb_op_select #(.NREQ(6)) u_sel (
    .req_i ({eng_push_i, eng_pop_i, host_rd_i, host_wr8_i, host_wr16_i, start_i}),
    .op_o  (op)
  );

  pbb_store #(.DEPTH(DEPTH)) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_i           (op),
    .wpair_i        (host_to_pair(host_wdata_i, straight_i)),
    .wbyte_i        (host_wdata_i[BYTE_W-1:0]),
    .rx_byte_i      (eng_rx_byte_i),
    .buf_o          (buf_q),
    .tx_o           (tx_count_o),
    .rx_o           (rx_count_o),
    .ev_wr_acc_o    (ev_wr_acc),
    .ev_wr16_acc_o  (ev_wr16_acc),
    .ev_wr_ign_o    (ev_wr_ign),
    .ev_tx_deep_o   (ev_tx_deep),
    .ev_pop_empty_o (ev_pop_empty),
    .ev_push_full_o (ev_push_full),
    .ev_rd_o        (ev_rd),
    .ev_rd_single_o (ev_rd_single),
    .ev_rd_zero_o   (ev_rd_zero)
  );

  pbb_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_i           (op),
    .ev_wr_acc_i    (ev_wr_acc),
    .ev_tx_deep_i   (ev_tx_deep),
    .ev_pop_empty_i (ev_pop_empty),
    .ev_push_full_i (ev_push_full),
    .ev_rd_i        (ev_rd),
    .ev_rd_single_i (ev_rd_single),
    .ev_rd_zero_i   (ev_rd_zero),
    .underflow_o    (underflow_o),
    .overrun_o      (overrun_o),
    .single_o       (single_byte_o),
    .tx_clr_o       (tx_ready_clr_o),
    .rx_clr_o       (rx_ready_clr_o)
  );

  // Byte offered to the engine: position (count - 1), or zero when empty
  function automatic logic [BYTE_W-1:0] head_byte(input logic [BUF_W-1:0] b,
                                                  input logic [CW-1:0] t);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (t == CW'(i + 1)) r = b[i*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  assign eng_tx_byte_o = head_byte(buf_q, tx_count_o);
  assign host_rdata_o  = pair_to_host(buf_q[HOST_W-1:0], straight_i);

endmodule

// File: rtl/pbb_byte_buffer_chk.sv
module pbb_byte_buffer_chk #(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int BUF_W = DEPTH * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [BUF_W-1:0] buf_q,
  input logic [CW-1:0]    tx_count_o,
  input logic [CW-1:0]    rx_count_o,
  input logic             underflow_o,
  input logic             overrun_o,
  input logic             single_byte_o,
  input logic             tx_ready_clr_o,
  input logic             rx_ready_clr_o,
  input logic             ev_wr16_acc,
  input logic             ev_wr_ign,
  input logic             ev_pop_empty,
  input logic             ev_push_full,
  input logic             ev_rd,
  input logic             ev_rd_single
);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (tx_count_o == '0) && (rx_count_o == '0) && (buf_q == '0)
                && !underflow_o && !overrun_o && !single_byte_o);

  assert_wr16_adds_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr16_acc |=> tx_count_o == $past(tx_count_o) + CW'(2));

  assert_ignored_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ign |=> $stable(buf_q) && $stable(tx_count_o) && $stable(rx_count_o)
                  && $stable(underflow_o) && !tx_ready_clr_o);

  assert_tx_pulse_deep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_clr_o |-> tx_count_o > CW'(2));

  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_empty |=> underflow_o && (tx_count_o == '0));

  assert_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_full |=> overrun_o && (rx_count_o == CW'(DEPTH)) && $stable(buf_q));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count_o <= CW'(DEPTH)) && (tx_count_o <= CW'(DEPTH)));

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_single |=> single_byte_o && (rx_count_o == '0));

  assert_read_clears_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> !overrun_o);

  assert_rx_pulse_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready_clr_o |-> rx_count_o == '0);

endmodule

bind pbb_byte_buffer pbb_byte_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .buf_q          (buf_q),
  .tx_count_o     (tx_count_o),
  .rx_count_o     (rx_count_o),
  .underflow_o    (underflow_o),
  .overrun_o      (overrun_o),
  .single_byte_o  (single_byte_o),
  .tx_ready_clr_o (tx_ready_clr_o),
  .rx_ready_clr_o (rx_ready_clr_o),
  .ev_wr16_acc    (ev_wr16_acc),
  .ev_wr_ign      (ev_wr_ign),
  .ev_pop_empty   (ev_pop_empty),
  .ev_push_full   (ev_push_full),
  .ev_rd          (ev_rd),
  .ev_rd_single   (ev_rd_single)
);

// File: tb/pbb_byte_buffer_tb.sv
module pbb_byte_buffer_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start_i, straight_i, host_wr16_i, host_wr8_i, host_rd_i;
  logic        eng_pop_i, eng_push_i;
  logic [15:0] host_wdata_i, host_rdata_o;
  logic [7:0]  eng_rx_byte_i, eng_tx_byte_o;
  logic [2:0]  tx_count_o, rx_count_o;
  logic        underflow_o, overrun_o, single_byte_o, tx_ready_clr_o, rx_ready_clr_o;

  pbb_byte_buffer u_dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the requirements
  logic [31:0] m_buf;
  int          m_tx, m_rx;
  bit          m_uf, m_ov, m_sb, m_txc, m_rxc;
  logic [31:0] rng = 32'h1badf00d;

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    return v ^ (v << 5);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int lo, hi, hb;
    lo = int'(m_buf[7:0]);
    hi = int'(m_buf[15:8]);
    hb = (m_tx == 0) ? 0 : int'((m_buf >> (8 * m_tx - 8)) & 32'hff);
    chk("R8", "read word", int'(host_rdata_o), straight_i ? (hi + lo * 256) : (lo + hi * 256));
    chk("R6", "engine byte", int'(eng_tx_byte_o), hb);
    chk("R2/R3", "tx count", int'(tx_count_o), m_tx);
    chk("R7", "rx count", int'(rx_count_o), m_rx);
    chk("R5/R6", "underflow", int'(underflow_o), int'(m_uf));
    chk("R7/R10", "overrun", int'(overrun_o), int'(m_ov));
    chk("R9", "single byte", int'(single_byte_o), int'(m_sb));
    chk("R5", "tx ready clear", int'(tx_ready_clr_o), int'(m_txc));
    chk("R10", "rx ready clear", int'(rx_ready_clr_o), int'(m_rxc));
  endtask

  // Apply one cycle of requests (called at a falling edge), step model, check
  task automatic step(input bit st, input bit w16, input bit w8, input bit rd,
                      input bit pop, input bit push, input logic [15:0] wd,
                      input logic [7:0] rb, input bit str);
    start_i = st; host_wr16_i = w16; host_wr8_i = w8; host_rd_i = rd;
    eng_pop_i = pop; eng_push_i = push; host_wdata_i = wd; eng_rx_byte_i = rb;
    straight_i = str;
    m_txc = 0; m_rxc = 0;
    if (st) begin
      m_buf = 0; m_tx = 0; m_rx = 0; m_uf = 0; m_ov = 0; m_sb = 0;
    end else if (w16 || w8) begin
      if (m_tx <= 2) begin
        if (w16) begin
          m_buf = {m_buf[15:0], (str ? wd : {wd[7:0], wd[15:8]})};
          m_tx += 2;
        end else begin
          m_buf = {m_buf[23:0], wd[7:0]};
          m_tx += 1;
        end
        m_uf = 0;
        m_txc = (m_tx > 2);
      end
    end else if (rd) begin
      m_ov = 0;
      if (m_rx == 1) begin m_sb = 1; m_rx = 0; end
      else if (m_rx == 2) m_rx = 0;
      else if (m_rx >= 3) begin m_buf = m_buf >> 16; m_rx -= 2; end
      m_rxc = (m_rx == 0);
    end else if (pop) begin
      if (m_tx == 0) m_uf = 1; else m_tx -= 1;
    end else if (push) begin
      if (m_rx == 4) m_ov = 1;
      else begin
        m_buf = (m_buf & ~(32'hff << (8 * m_rx))) | (32'(rb) << (8 * m_rx));
        m_rx += 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    start_i = 0; host_wr16_i = 0; host_wr8_i = 0; host_rd_i = 0;
    eng_pop_i = 0; eng_push_i = 0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; straight_i = 0; host_wr16_i = 0; host_wr8_i = 0;
    host_rd_i = 0; eng_pop_i = 0; eng_push_i = 0; host_wdata_i = 0; eng_rx_byte_i = 0;
    m_buf = 0; m_tx = 0; m_rx = 0; m_uf = 0; m_ov = 0; m_sb = 0; m_txc = 0; m_rxc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset read word", int'(host_rdata_o), 0);
    compare_all();

    // Directed transmit: word then odd byte, low byte first
    step(0, 1, 0, 0, 0, 0, 16'h1234, 8'h00, 0);
    step(0, 0, 1, 0, 0, 0, 16'h0056, 8'h00, 0);
    // R4: full enough, this write is dropped
    step(0, 1, 0, 0, 0, 0, 16'hbeef, 8'h00, 0);
    chk("R4", "tx count after ignored write", int'(tx_count_o), 3);
    chk("R4", "head byte after ignored write", int'(eng_tx_byte_o), 'h34);
    chk("R4", "no tx clear pulse on ignored write", int'(tx_ready_clr_o), 0);
    step(0, 0, 0, 0, 1, 0, 16'h0, 8'h00, 0);
    chk("R6", "second byte out", int'(eng_tx_byte_o), 'h12);
    step(0, 0, 0, 0, 1, 0, 16'h0, 8'h00, 0);
    chk("R3", "odd byte last", int'(eng_tx_byte_o), 'h56);
    step(0, 0, 0, 0, 1, 0, 16'h0, 8'h00, 0);
    step(0, 0, 0, 0, 1, 0, 16'h0, 8'h00, 0);
    chk("R6", "underflow on empty pop", int'(underflow_o), 1);
    chk("R6", "empty head byte", int'(eng_tx_byte_o), 0);
    // R11: write and pop together, only the write acts
    step(0, 1, 0, 0, 1, 1, 16'ha5c3, 8'h77, 1);
    chk("R11", "write wins over pop and push", int'(tx_count_o), 2);
    chk("R11", "push lost to write", int'(rx_count_o), 0);
    // R1: start clears everything even with other requests
    step(1, 1, 0, 1, 1, 1, 16'h1111, 8'h22, 0);
    chk("R1", "start clears tx", int'(tx_count_o), 0);

    // Near-exhaustive random sweep against the model
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] a, b;
      rng = xs(rng); a = rng;
      rng = xs(rng); b = rng;
      step(a[5:0] == 6'd0, a[7:6] == 2'd0, a[10:8] == 3'd0, a[12:11] == 2'd0,
           a[14:13] == 2'd0, a[15], b[15:0], b[23:16], a[16]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule